// File: doc/BRIEF.md
# Masked Vector Load/Store Unit

This unit moves one 256-bit vector operand between a register-side command interface and a simple 32-bit byte-addressed memory port, under a per-element mask. The operand is read as eight 32-bit elements or four 64-bit elements. On a load, only the selected elements are fetched from memory and the unselected elements of the result are forced to zero. On a store, only the selected elements are written, so memory bytes that belong to unselected elements are never touched.

A command carries the direction, the element size, a base address, a mask vector and store data. The unit walks the selected 32-bit words in ascending address order and issues one memory request per selected word, holding each request until the memory acknowledges it. A one-cycle done strobe marks completion, and the assembled load result is presented alongside it. An all-zero mask completes at once, with no memory traffic. The address need not be aligned to the 32-byte vector size.

Top module: `vmask_lsu`

## Requirements
- R1: An element is selected exactly when the most significant bit of the matching element of `cmd_mask` is 1 (bit 31 of each 32-bit element when `cmd_wide`=0, bit 63 of each 64-bit element when `cmd_wide`=1); all other mask bits are ignored.
- R2: A load (`cmd_store`=0) issues one read (`mem_we`=0) per selected 32-bit word i at address base+4*i, places the returned `mem_rdata` in bits [32*i+31:32*i] of `ld_result`, and returns zero in every unselected word.
- R3: A store (`cmd_store`=1) issues one write (`mem_we`=1, `mem_be`=4'b1111) per selected word i carrying bits [32*i+31:32*i] of `cmd_data`, and issues no request for unselected words, so their memory bytes stay unchanged.
- R4: Requests are issued one at a time in ascending address order; a request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high.
- R5: With no selected element, the unit issues no memory request and raises `done` in the cycle after acceptance.
- R6: `done` is high for one cycle, in the cycle after the clock edge that takes the last `mem_ack`; `ld_result` is valid while `done` is high and holds until the next command is accepted.
- R7: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both high; `cmd_valid` while busy has no effect on the requests issued.
- R8: Any 4-byte-aligned base address is valid with no 32-byte alignment; the two low address bits are ignored (treated as zero).
- R9: A synchronous reset drops any pending request, clears `done` and returns the unit to idle with `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| cmd_addr | input | 32 | Byte base address |
| cmd_mask | input | 256 | Mask vector, element MSB selects |
| cmd_data | input | 256 | Store data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed, read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| ld_result | output | 256 | Load result |

## Verification
The bench goes after mask vectors whose low bits are set on unselected elements, where a design that ORs the element bits instead of taking the MSB would fetch or write extra words, and 64-bit mode with only the low half's MSB set, where a design that decodes per 32-bit word would select half an element. Stores with scattered masks are followed by a full comparison of memory, which exposes any write to an unselected word, and loads check that unselected lanes read zero rather than stale data. Zero masks must finish in the cycle after acceptance with no request, commands pushed while busy must not add accesses, and a reset with a request stalled must drop it at once.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } lsu_state_e;
endpackage

// File: rtl/vlsu_lane_sel.sv
module vlsu_lane_sel #(
    parameter int VEC_W  = 256,
    parameter int WORD_W = 32,
    localparam int NW    = VEC_W / WORD_W
) (
    input  logic [VEC_W-1:0] mask,
    input  logic             wide,
    output logic [NW-1:0]    sel
);
    logic [NW-1:0] sel_narrow;
    logic [NW-1:0] sel_wide;

    for (genvar i = 0; i < NW; i++) begin : g_word
        assign sel_narrow[i] = mask[WORD_W*i + WORD_W - 1];
        assign sel_wide[i]   = mask[2*WORD_W*(i/2) + 2*WORD_W - 1];
    end

    assign sel = wide ? sel_wide : sel_narrow;
endmodule

// File: rtl/vlsu_pick_next.sv
module vlsu_pick_next #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
        found = |vec;
    end
endmodule

// File: rtl/vmask_lsu.sv
module vmask_lsu
    import vlsu_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic              cmd_wide,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [VEC_W-1:0]  cmd_mask,
    input  logic [VEC_W-1:0]  cmd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W/8-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [VEC_W-1:0]  ld_result
);
    localparam int NW   = VEC_W / WORD_W;
    localparam int IW   = (NW > 1) ? $clog2(NW) : 1;
    localparam int BE_W = WORD_W / 8;
    localparam int OFF  = $clog2(BE_W);

    typedef struct packed {
        lsu_state_e        state;
        logic              store;
        logic [ADDR_W-1:0] base;
        logic [NW-1:0]     sel;
        logic [IW-1:0]     idx;
        logic [VEC_W-1:0]  data;
        logic [VEC_W-1:0]  res;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [NW-1:0] sel_new;
    logic [NW-1:0] sel_rest;
    logic          first_found, next_found;
    logic [IW-1:0] first_idx, next_idx;
    logic          accept;

    vlsu_lane_sel #(.VEC_W(VEC_W), .WORD_W(WORD_W)) i_lane_sel (
        .mask (cmd_mask),
        .wide (cmd_wide),
        .sel  (sel_new)
    );

    vlsu_pick_next #(.N(NW)) i_pick_first (
        .vec   (sel_new),
        .found (first_found),
        .idx   (first_idx)
    );

    always_comb begin
        for (int i = 0; i < NW; i++) begin
            sel_rest[i] = r_q.sel[i] && (IW'(i) > r_q.idx);
        end
    end

    vlsu_pick_next #(.N(NW)) i_pick_next (
        .vec   (sel_rest),
        .found (next_found),
        .idx   (next_idx)
    );

    assign accept = cmd_valid && (r_q.state == ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (accept) begin
            r_d.store = cmd_store;
            r_d.base  = {cmd_addr[ADDR_W-1:OFF], {OFF{1'b0}}};
            r_d.sel   = sel_new;
            r_d.data  = cmd_data;
            r_d.res   = '0;
            r_d.idx   = first_idx;
            if (first_found) begin
                r_d.state = ST_BUSY;
            end else begin
                r_d.done = 1'b1;
            end
        end else if (r_q.state == ST_BUSY && mem_ack) begin
            if (!r_q.store) begin
                r_d.res[r_q.idx*WORD_W +: WORD_W] = mem_rdata;
            end
            if (next_found) begin
                r_d.idx = next_idx;
            end else begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == ST_IDLE);
    assign mem_req   = (r_q.state == ST_BUSY);
    assign mem_we    = r_q.store;
    assign mem_addr  = r_q.base + (ADDR_W'(r_q.idx) << OFF);
    assign mem_be    = {BE_W{1'b1}};
    assign mem_wdata = r_q.data[r_q.idx*WORD_W +: WORD_W];
    assign done      = r_q.done;
    assign ld_result = r_q.res;

    // R4: a pending request stays put until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R4: after an acknowledge the next word is strictly higher
    a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req || (r_q.idx > $past(r_q.idx)));

    // R5: empty selection finishes at once without traffic
    a_r5_zero_mask: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && !(|sel_new) |=> done && !mem_req);

    // R6: completion is only signalled from the idle state
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready && !mem_req);

    // R7: commands offered while busy do not disturb the operation
    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> $stable(r_q.base) && $stable(r_q.sel) && $stable(r_q.store));
endmodule

// File: tb/test_vmask_lsu.sv
module test_vmask_lsu;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic         cmd_store = 1'b0;
    logic         cmd_wide = 1'b0;
    logic [31:0]  cmd_addr = '0;
    logic [255:0] cmd_mask = '0;
    logic [255:0] cmd_data = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [3:0]   mem_be;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         done;
    logic [255:0] ld_result;

    always #4 clk = ~clk;

    vmask_lsu i_vmask_lsu (
        .clk, .rst, .cmd_valid, .cmd_ready, .cmd_store, .cmd_wide, .cmd_addr,
        .cmd_mask, .cmd_data, .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata,
        .mem_ack, .mem_rdata, .done, .ld_result
    );

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
    } acc_t;

    acc_t         acc_q[$];
    logic [255:0] res_q[$];
    logic         isld_q[$];
    string        tag_q[$];

    logic [31:0] mem [0:255];
    logic [31:0] exp_mem [0:255];
    int errs = 0;
    int checks = 0;
    int acc_cnt = 0;
    int wait_cnt = 0;
    bit hold_mem = 0;

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // memory model and access scoreboard
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && !hold_mem && !rst) begin
                if (wait_cnt < (acc_cnt % 3)) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    acc_cnt++;
                    if (acc_q.size() == 0) begin
                        chk(0, "R7", "unexpected access", 256'(mem_addr), '0);
                    end else begin
                        acc_t e;
                        e = acc_q.pop_front();
                        chk(mem_addr == e.addr, "R4", "address/order", 256'(mem_addr), 256'(e.addr));
                        chk(mem_we == e.we, "R2", "direction", 256'(mem_we), 256'(e.we));
                        if (e.we) begin
                            chk(mem_wdata == e.wdata && mem_be == 4'hF, "R3", "write data/enables",
                                {mem_be, mem_wdata}, {4'hF, e.wdata});
                        end
                    end
                    if (mem_we) begin
                        for (int b = 0; b < 4; b++) begin
                            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                        end
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // completion monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done && !rst) begin
                if (res_q.size() == 0) begin
                    chk(0, "R6", "unexpected done", 256'(done), '0);
                end else begin
                    logic [255:0] er;
                    logic         il;
                    string        tg;
                    er = res_q.pop_front();
                    il = isld_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(acc_q.size() == 0, "R6", "done before last access", 256'(acc_q.size()), '0);
                    if (il) chk(ld_result == er, tg, "load result", ld_result, er);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        chk(0, "R6", "watchdog expired", '0, '0);
        finish_run();
    end

    function automatic logic [255:0] mk_mask(bit wide, logic [7:0] pick, bit junk);
        logic [255:0] m = '0;
        int n = wide ? 4 : 8;
        int w = wide ? 64 : 32;
        for (int e = 0; e < n; e++) begin
            if (junk) for (int b = 0; b < w - 1; b++) m[e*w + b] = 1'b1;
            m[e*w + w - 1] = pick[e];
        end
        return m;
    endfunction

    task automatic issue(bit st, bit wide, logic [31:0] addr, logic [7:0] pick, bit junk,
                         logic [255:0] data, bit busy_junk, string tag);
        logic [255:0] m = mk_mask(wide, pick, junk);
        logic [31:0]  base = {addr[31:2], 2'b00};
        logic [255:0] er = '0;
        bit           any = 0;
        for (int i = 0; i < 8; i++) begin
            bit s = wide ? pick[i/2] : pick[i];
            if (s) begin
                acc_t a;
                logic [31:0] wa = base + 32'(4*i);
                any = 1;
                a.addr = wa; a.we = st; a.wdata = data[32*i +: 32];
                acc_q.push_back(a);
                if (st) exp_mem[wa[9:2]] = data[32*i +: 32];
                else er[32*i +: 32] = exp_mem[wa[9:2]];
            end
        end
        res_q.push_back(er);
        isld_q.push_back(!st);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_store = st; cmd_wide = wide; cmd_addr = addr;
        cmd_mask = m; cmd_data = data;
        @(posedge clk);
        @(negedge clk);
        if (!any) begin
            chk(done == 1'b1 && mem_req == 1'b0, "R5", "zero mask finish",
                256'({done, mem_req}), 256'(2'b10));
        end
        if (busy_junk) begin
            cmd_store = 1; cmd_wide = 0; cmd_addr = 32'h300; cmd_mask = '1; cmd_data = '1;
        end else begin
            cmd_valid = 0;
        end
        while (!done) @(negedge clk);
        cmd_valid = 0;
        if (st || !any) begin
            bit same = 1;
            for (int w = 0; w < 256; w++) if (mem[w] !== exp_mem[w]) same = 0;
            chk(same, st ? tag : "R5", "memory image after command", 256'(same), 256'(1));
        end
    endtask

    initial begin
        for (int w = 0; w < 256; w++) begin
            mem[w] = 32'hA5000000 ^ (w * 32'h01010101);
            exp_mem[w] = mem[w];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(cmd_ready && !mem_req && !done, "R9", "reset state",
            256'({cmd_ready, mem_req, done}), 256'(3'b100));

        issue(0, 0, 32'h040, 8'hFF, 0, '0, 0, "R2");
        issue(0, 0, 32'h104, 8'b1010_0101, 1, '0, 0, "R1");
        issue(0, 1, 32'h088, 8'b0000_1010, 1, '0, 0, "R1");
        issue(1, 0, 32'h10B, 8'b1001_0110, 1,
              256'h11111111_22222222_33333333_44444444_55555555_66666666_77777777_88888888, 0, "R8");
        issue(1, 1, 32'h184, 8'b0000_0100, 0,
              256'hDEADBEEF_CAFEF00D_01234567_89ABCDEF_FEDCBA98_76543210_0F0F0F0F_F0F0F0F0, 1, "R7");
        issue(1, 1, 32'h1C4, 8'b0000_1001, 1, {8{32'h5A5A0000}} ^ {8{32'h00001234}}, 0, "R3");
        issue(0, 0, 32'h108, 8'hFF, 0, '0, 0, "R2");
        issue(0, 1, 32'h184, 8'b0000_0110, 0, '0, 0, "R2");
        issue(0, 0, 32'h200, 8'h00, 1, '0, 0, "R5");
        issue(1, 1, 32'h200, 8'h00, 1, '1, 0, "R5");

        // reset with a stalled request pending
        hold_mem = 1;
        @(negedge clk);
        cmd_valid = 1; cmd_store = 0; cmd_wide = 0; cmd_addr = 32'h020;
        cmd_mask = mk_mask(0, 8'h0F, 0);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        @(negedge clk);
        @(negedge clk);
        chk(mem_req == 1'b1, "R4", "request held while stalled", 256'(mem_req), 256'(1));
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !mem_req && !done, "R9", "reset drops request",
            256'({cmd_ready, mem_req, done}), 256'(3'b100));
        rst = 0;
        hold_mem = 0;

        issue(0, 0, 32'h0FC, 8'b1100_0011, 0, '0, 0, "R6");
        repeat (4) @(negedge clk);
        chk(res_q.size() == 0 && acc_q.size() == 0, "R6", "scoreboard drained",
            256'(res_q.size() + acc_q.size()), '0);
        finish_run();
    end
endmodule